// File: doc/BRIEF.md
# Glitch-free clock gating controller

This block sits between a set of free-running source clocks and the output pads that carry them off chip. It opens and closes a gate on each clock so that outputs can be stopped and restarted cleanly. A stopped output always rests low. No output ever emits a shortened high or low phase. Each output is driven from its own source clock, and its gate changes state only while that clock is low.

Three controls decide whether an output runs:

- **Per-output enable bit.** Each output has its own enable bit from a control register.
- **Stop request.** A shared active-low stop request halts every output that belongs to the stoppable group. Outputs marked as free-running, such as fixed reference clocks, ignore the stop request.
- **Two-bit mode field.** This field can release every pad driver into high impedance. In the other three codes the clocks pass normally.

The stop request is asynchronous. A configurable synchroniser brings it into each clock domain. Each domain holds its own gate register and its own pad output-enable register.

Top module: `clk_gate_ctrl`

## Requirements
- R1: An output that is stopped or disabled stays at logic 0 and shows no rising edge for as long as it remains stopped.
- R2: Every high phase on `clk_out[i]` begins on a rising edge of `clk_src[i]` and lasts exactly one half period of that source. This holds during stop, restart, enable changes and disable.
- R3: Enable bit `en_bits[i]` = 1 lets output i run. `en_bits[i]` = 0 holds it low, starting from the next falling edge of `clk_src[i]`.
- R4: For an output in the stoppable group (`FREE_MASK[i]` = 0), driving `stop_n` to 0 causes no rising edge on `clk_out[i]` later than `SYNC_STAGES` periods of `clk_src[i]` after the request.
- R5: After `stop_n` returns to 1, an enabled output in the stoppable group shows its first full rising edge within `SYNC_STAGES`+1 periods of its source.
- R6: `mode` = 2'b11 drives every `clk_oe[i]` to 0 from the next falling edge of the source. Codes 2'b00, 2'b01 and 2'b10 keep every `clk_oe[i]` at 1 and leave the gated clocks unchanged.
- R7: An output with `FREE_MASK[i]` = 1 ignores `stop_n` and runs whenever its enable bit is 1.
- R8: While `rst` is 1, every gate is open and every `clk_oe[i]` is 1. This holds regardless of `stop_n`, `en_bits` and `mode`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | N_CLK | Free-running source clocks, one per output |
| rst | input | 1 | Synchronous active-high reset, applied in every domain |
| stop_n | input | 1 | Asynchronous active-low stop request for the stoppable group |
| en_bits | input | N_CLK | Per-output enable bits, 1 = running |
| mode | input | 2 | Output mode: 00 normal, 01/10 spread settings (clocks pass), 11 high impedance |
| clk_out | output | N_CLK | Gated clocks |
| clk_oe | output | N_CLK | Per-output pad driver enable, 1 = drive |

## Verification
The assertions make three assumptions about the inputs:

- `rst` stays high for several periods of the slowest source.
- `en_bits` and `mode` are quasi-static register bits that never change on a source clock edge.
- `stop_n` may change at any time, because it passes through the synchroniser first.

The stimulus changes every input a quarter nanosecond away from the half-nanosecond grid on which all source edges fall, so no input ever coincides with a sampling edge. Each step is held long enough for the slowest domain to settle before the bench measures the outputs.

// File: rtl/cgc_pkg.sv
package cgc_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'b00,
    MODE_SPREAD_A = 2'b01,
    MODE_SPREAD_B = 2'b10,
    MODE_HIZ      = 2'b11
  } out_mode_e;

  function automatic logic mode_is_hiz(input logic [1:0] m);
    return out_mode_e'(m) == MODE_HIZ;
  endfunction

endpackage

// File: rtl/cgc_sync.sv
module cgc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  generate
    if (STAGES == 0) begin : g_bypass
      wire unused_ok = &{1'b0, clk, rst};
      assign dout = din;
    end else begin : g_chain
      logic [STAGES-1:0] stage;
      always_ff @(posedge clk) begin
        if (rst) stage <= '1;
        else     stage <= {stage[STAGES-2:0], din};
      end
      assign dout = stage[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/cgc_gate.sv
module cgc_gate #(
  parameter bit FREE        = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic stop_n,
  input  logic en_bit,
  input  logic hiz,
  output logic gclk,
  output logic oe
);

  logic want;
  logic en_q;
  logic oe_q;
  logic rise_gate;

  generate
    if (FREE) begin : g_free
      wire unused_ok = &{1'b0, stop_n};
      assign want = en_bit;
    end else begin : g_stoppable
      logic run_sync;
      cgc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (stop_n),
        .dout (run_sync)
      );
      assign want = en_bit & run_sync;
    end
  endgenerate

  // Gate and pad enable change only while the source is low.
  always_ff @(negedge clk) begin
    if (rst) begin
      en_q <= 1'b1;
      oe_q <= 1'b1;
    end else begin
      en_q <= want;
      oe_q <= ~hiz;
    end
  end

  // Gate value seen when the current high phase started.
  always_ff @(posedge clk) rise_gate <= en_q;

  assign gclk = clk & en_q;
  assign oe   = oe_q;

  always @(negedge clk) begin
    if (!rst) begin
      AST_FULL_HIGH: assert (en_q == rise_gate); // R2
    end
  end

  AST_DISABLE_LOW: assert property (@(negedge clk) disable iff (rst)
    !en_bit |=> !en_q); // R3

  AST_HIZ_OE: assert property (@(negedge clk) disable iff (rst)
    hiz |=> !oe); // R6

  AST_DRIVE_OE: assert property (@(negedge clk) disable iff (rst)
    !hiz |=> oe); // R6

  generate
    if (FREE) begin : g_free_chk
      AST_FREE_RUN: assert property (@(negedge clk) disable iff (rst)
        en_bit |=> en_q); // R7
    end else begin : g_stop_chk
      AST_STOP_GATE: assert property (@(negedge clk) disable iff (rst)
        !g_stoppable.run_sync |=> !en_q); // R4
      AST_RESTART: assert property (@(negedge clk) disable iff (rst)
        (g_stoppable.run_sync && en_bit) |=> en_q); // R5
    end
  endgenerate

endmodule

// File: rtl/clk_gate_ctrl.sv
module clk_gate_ctrl #(
  parameter int                N_CLK       = 4,
  parameter logic [N_CLK-1:0]  FREE_MASK   = 4'b0001,
  parameter int                SYNC_STAGES = 2
) (
  input  logic [N_CLK-1:0] clk_src,
  input  logic             rst,
  input  logic             stop_n,
  input  logic [N_CLK-1:0] en_bits,
  input  logic [1:0]       mode,
  output logic [N_CLK-1:0] clk_out,
  output logic [N_CLK-1:0] clk_oe
);

  logic hiz;
  assign hiz = cgc_pkg::mode_is_hiz(mode);

  for (genvar g = 0; g < N_CLK; g++) begin : g_out
    cgc_gate #(
      .FREE        (FREE_MASK[g]),
      .SYNC_STAGES (SYNC_STAGES)
    ) u_gate (
      .clk    (clk_src[g]),
      .rst    (rst),
      .stop_n (stop_n),
      .en_bit (en_bits[g]),
      .hiz    (hiz),
      .gclk   (clk_out[g]),
      .oe     (clk_oe[g])
    );
  end

endmodule

// File: tb/clk_gate_ctrl_bench.sv
`timescale 1ns/1ps
module clk_gate_ctrl_bench;

  localparam int N = 4;
  localparam logic [N-1:0] FREE = 4'b0001;
  localparam int STAGES = 2;
  localparam realtime HALF [N] = '{2.5, 3.5, 5.0, 3.0};
  localparam int PER [N] = '{5, 7, 10, 6};

  logic [N-1:0] clk_src = '0;
  logic rst = 1'b1;
  logic stop_n = 1'b0;
  logic [N-1:0] en_bits = '0;
  logic [1:0] mode = 2'b11;
  logic [N-1:0] clk_out;
  logic [N-1:0] clk_oe;

  int total = 0;
  int bad = 0;
  int rises [N];

  clk_gate_ctrl #(.N_CLK(N), .FREE_MASK(FREE), .SYNC_STAGES(STAGES)) u_clk_gate_ctrl (
    .clk_src (clk_src),
    .rst     (rst),
    .stop_n  (stop_n),
    .en_bits (en_bits),
    .mode    (mode),
    .clk_out (clk_out),
    .clk_oe  (clk_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  for (genvar i = 0; i < N; i++) begin : g_clk
    realtime rise_t = 0.0;
    initial rises[i] = 0;
    initial forever #(HALF[i]) clk_src[i] = ~clk_src[i];
    always @(posedge clk_out[i]) begin
      rise_t = $realtime;
      rises[i]++;
      if (!rst) chk(clk_src[i] === 1'b1, "R2 rise on source edge", int'(clk_src[i]), 1);
    end
    always @(negedge clk_out[i]) begin
      if (!rst && rise_t > 0.0)
        chk(($realtime - rise_t) == HALF[i], "R2 full high phase",
            int'(($realtime - rise_t) * 1000.0), int'(HALF[i] * 1000.0));
    end
  end

  initial begin : watchdog
    #150000;
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int snap [N];
    #10.25;
    // R8: reset opens all gates and drives oe despite stop, disable, hi-Z
    for (int i = 0; i < N; i++) snap[i] = rises[i];
    #40;
    for (int i = 0; i < N; i++) begin
      chk(rises[i] - snap[i] >= 3, "R8 runs in reset", rises[i] - snap[i], 3);
      chk(clk_oe[i] === 1'b1, "R8 oe in reset", int'(clk_oe[i]), 1);
    end
    rst = 1'b0;
    #40;

    // Sweep mode x stop x enables
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 2; s++) begin
        for (int e = 0; e < 16; e++) begin
          mode = 2'(m);
          stop_n = 1'(s);
          en_bits = 4'(e);
          #40;
          for (int i = 0; i < N; i++) snap[i] = rises[i];
          #40;
          for (int i = 0; i < N; i++) begin
            bit run;
            run = e[i] && (FREE[i] || s == 1);
            if (run) begin
              chk(rises[i] - snap[i] >= 3,
                  FREE[i] ? "R7 free output runs" : "R3 enabled output runs",
                  rises[i] - snap[i], 3);
            end else begin
              chk(rises[i] == snap[i],
                  e[i] ? "R1 stopped output idle" : "R3 disabled output idle",
                  rises[i] - snap[i], 0);
              chk(clk_out[i] === 1'b0, "R1 parked low", int'(clk_out[i]), 0);
            end
            chk(clk_oe[i] === (m != 3), "R6 mode drives oe", int'(clk_oe[i]), int'(m != 3));
          end
        end
      end
    end

    // R4 / R5 latency for each stoppable output
    mode = 2'b00;
    en_bits = '1;
    for (int i = 0; i < N; i++) begin
      if (!FREE[i]) begin
        stop_n = 1'b1;
        #40;
        stop_n = 1'b0;
        #(STAGES * PER[i]);
        snap[i] = rises[i];
        #(3 * PER[i]);
        chk(rises[i] == snap[i], "R4 stop latency", rises[i] - snap[i], 0);
        chk(clk_out[i] === 1'b0, "R1 parked low after stop", int'(clk_out[i]), 0);
        snap[i] = rises[i];
        stop_n = 1'b1;
        #((STAGES + 1) * PER[i]);
        chk(rises[i] > snap[i], "R5 restart latency", rises[i] - snap[i], 1);
      end
    end

    #20;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule